// File: doc/BRIEF.md
# Cascadable 16-bit Arithmetic Logic Unit

This block is a purely combinational 16-bit arithmetic logic unit. It takes two operands, a 3-bit function code and a carry-in, and returns a result, a zero flag, an overflow flag and a carry-out. It also returns active-low group generate and propagate terms, so that several units can be joined through an external lookahead carry unit into a wider word.

There are three arithmetic functions: A plus B, inverted A plus B, and A plus inverted B. Each one also adds the carry-in, so that with the carry-in set the second and third compute B minus A and A minus B. The logic functions are XOR, OR and AND. Two further codes give a constant all-zeros or all-ones result.

Carries come from an explicit 16-stage prefix chain of generate and OR-type propagate terms. The two subtraction forms obtain their flags by inverting one operand before the chain.

Top module: `lookahead_alu16`

## Requirements
- R1: With fsel=3'b011 the result is the low 16 bits of A+B+cin. With fsel=3'b001 it is the low 16 bits of (~A)+B+cin. With fsel=3'b010 it is the low 16 bits of A+(~B)+cin.
- R2: With fsel=3'b100 the result is A XOR B. With 3'b101 it is A OR B. With 3'b110 it is A AND B.
- R3: With fsel=3'b000 the result is 16'h0000. With fsel=3'b111 it is 16'hFFFF.
- R4: zero is 1 exactly when all 16 result bits are 0, for every function code.
- R5: In an arithmetic function, cout is bit 16 of the 17-bit sum of the two operands as presented to the adder (one of them inverted for 001 and 010) plus cin.
- R6: In an arithmetic function, ovf is 1 exactly when the two adder operands have equal sign bits and the result sign differs from them.
- R7: In an arithmetic function, gen_n is 0 exactly when the adder operands produce a carry out of bit 15 with cin taken as 0. prop_n is 0 exactly when every bit has at least one adder operand bit set.
- R8: For codes 000, 100, 101, 110 and 111, the outputs are fixed: cout=0, ovf=0, gen_n=1 and prop_n=1.
- R9: Every output follows its inputs within the same cycle, with no storage. A change of inputs is visible before the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| fsel | input | 3 | Function code |
| cin | input | 1 | Carry into bit 0 |
| res | output | 16 | Result |
| zero | output | 1 | Result is all zeros |
| ovf | output | 1 | Signed overflow, arithmetic codes only |
| cout | output | 1 | Carry out of bit 15 |
| gen_n | output | 1 | Group generate, active low |
| prop_n | output | 1 | Group propagate, active low |

## Verification
Every result and flag is combinational, so each is due in the same cycle in which its inputs are applied. The bench changes the inputs 1 ns after a rising edge and samples all outputs 3 ns later, which is still before the next edge. Expected values come from a behavioural 17-bit addition of the adder operands. The group terms are modelled as the carry-out with cin forced to 0 and as the AND of the bitwise OR.

// File: rtl/lookahead_alu16.sv
module lookahead_alu16 #(
  parameter int W = 16
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic [2:0]   fsel,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         zero,
  output logic         ovf,
  output logic         cout,
  output logic         gen_n,
  output logic         prop_n
);
  localparam logic [2:0] F_CLR = 3'b000, F_NAB = 3'b001, F_ANB = 3'b010,
                         F_ADD = 3'b011, F_XOR = 3'b100, F_OR  = 3'b101,
                         F_AND = 3'b110, F_SET = 3'b111;

  logic [W-1:0] xa, xb, g, p, gg, pp, sum;
  logic [W:0]   c;
  logic         arith;

  assign arith = (fsel == F_NAB) || (fsel == F_ANB) || (fsel == F_ADD);
  assign xa    = (fsel == F_NAB) ? ~opa : opa;
  assign xb    = (fsel == F_ANB) ? ~opb : opb;
  assign g     = xa & xb;
  assign p     = xa | xb;

  assign gg[0] = g[0];
  assign pp[0] = p[0];
  assign c[0]  = cin;
  genvar i;
  generate
    for (i = 1; i < W; i++) begin : g_chain
      assign gg[i] = g[i] | (p[i] & gg[i-1]);
      assign pp[i] = p[i] & pp[i-1];
    end
    for (i = 1; i <= W; i++) begin : g_carry
      assign c[i] = gg[i-1] | (pp[i-1] & cin);
    end
  endgenerate

  assign sum = xa ^ xb ^ c[W-1:0];

  always_comb begin
    case (fsel)
      F_CLR:                res = '0;
      F_NAB, F_ANB, F_ADD:  res = sum;
      F_XOR:                res = opa ^ opb;
      F_OR:                 res = opa | opb;
      F_AND:                res = opa & opb;
      F_SET:                res = '1;
      default:              res = '0;
    endcase
  end

  assign zero   = ~|res;
  assign cout   = arith & c[W];
  assign ovf    = arith & (c[W] ^ c[W-1]);
  assign gen_n  = arith ? ~gg[W-1] : 1'b1;
  assign prop_n = arith ? ~pp[W-1] : 1'b1;

  logic [W:0] ref_sum;
  assign ref_sum = {1'b0, xa} + {1'b0, xb} + {{W{1'b0}}, cin};

  always_comb begin
    if (arith) begin
      p_sum_matches_adder_r1_r5: assert ({cout, res} == ref_sum);
      p_overflow_sign_rule_r6: assert (ovf == ((xa[W-1] == xb[W-1]) && (res[W-1] != xa[W-1])));
      p_generate_forces_carry_r7: assert (gen_n || cout);
      p_propagate_passes_cin_r7: assert (prop_n || !cin || cout);
    end else begin
      p_idle_flags_r8: assert (!cout && !ovf && gen_n && prop_n);
    end
    if (fsel == F_CLR) p_clear_result_r3: assert (res == '0 && zero);
  end
endmodule

// File: tb/sim_lookahead_alu16.sv
module sim_lookahead_alu16;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] opa, opb, res;
  logic [2:0]  fsel;
  logic        cin, zero, ovf, cout, gen_n, prop_n;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  lookahead_alu16 u0 (.opa(opa), .opb(opb), .fsel(fsel), .cin(cin), .res(res),
    .zero(zero), .ovf(ovf), .cout(cout), .gen_n(gen_n), .prop_n(prop_n));

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] a, input logic [15:0] b, input logic [2:0] f, input logic ci);
    @(posedge clk);
    #1;
    opa = a; opb = b; fsel = f; cin = ci;
    #3;
  endtask

  task automatic arith_case(input logic [15:0] a, input logic [15:0] b, input logic [2:0] f, input logic ci);
    logic [15:0] xa, xb;
    logic [16:0] s, s0;
    logic ov;
    apply(a, b, f, ci);
    xa = (f == 3'b001) ? ~a : a;
    xb = (f == 3'b010) ? ~b : b;
    s  = {1'b0, xa} + {1'b0, xb} + {16'd0, ci};
    s0 = {1'b0, xa} + {1'b0, xb};
    ov = (xa[15] == xb[15]) && (s[15] != xa[15]);
    chk("R1", "sum", {16'd0, res}, {16'd0, s[15:0]});
    chk("R4", "zero", {31'd0, zero}, {31'd0, s[15:0] == 16'd0});
    chk("R5", "cout", {31'd0, cout}, {31'd0, s[16]});
    chk("R6", "ovf", {31'd0, ovf}, {31'd0, ov});
    chk("R7", "gen_n", {31'd0, gen_n}, {31'd0, ~s0[16]});
    chk("R7", "prop_n", {31'd0, prop_n}, {31'd0, ~&(xa | xb)});
  endtask

  task automatic other_case(input logic [15:0] a, input logic [15:0] b, input logic [2:0] f, input logic ci);
    logic [15:0] e;
    apply(a, b, f, ci);
    case (f)
      3'b100:  e = a ^ b;
      3'b101:  e = a | b;
      3'b110:  e = a & b;
      3'b111:  e = 16'hFFFF;
      default: e = 16'h0000;
    endcase
    chk((f == 3'b000 || f == 3'b111) ? "R3" : "R2", "result", {16'd0, res}, {16'd0, e});
    chk("R4", "zero", {31'd0, zero}, {31'd0, e == 16'd0});
    chk("R8", "flags", {28'd0, cout, ovf, gen_n, prop_n}, 32'h3);
  endtask

  task automatic test_directed();
    arith_case(16'h0000, 16'h0000, 3'b011, 1'b0);
    arith_case(16'hFFFF, 16'h0001, 3'b011, 1'b0);
    arith_case(16'hFFFF, 16'h0000, 3'b011, 1'b1);
    arith_case(16'h7FFF, 16'h0001, 3'b011, 1'b0);
    arith_case(16'h8000, 16'h8000, 3'b011, 1'b0);
    arith_case(16'h1234, 16'h1234, 3'b001, 1'b1);
    arith_case(16'h0005, 16'h0003, 3'b010, 1'b1);
    arith_case(16'h8000, 16'h0001, 3'b010, 1'b1);
    arith_case(16'h0F0F, 16'hF0F0, 3'b011, 1'b0);
  endtask

  task automatic test_random();
    for (int k = 0; k < 600; k++) begin
      logic [2:0] f;
      f = 3'($urandom_range(1, 3));
      arith_case(16'($urandom), 16'($urandom), f, 1'($urandom));
    end
  endtask

  task automatic test_nonarith();
    for (int k = 0; k < 200; k++) begin
      logic [2:0] f;
      f = 3'($urandom_range(0, 4));
      if (f != 3'b000) f = f + 3'd3;
      other_case(16'($urandom), 16'($urandom), f, 1'($urandom));
    end
    other_case(16'hAAAA, 16'h5555, 3'b110, 1'b1);
    other_case(16'h1234, 16'h1234, 3'b100, 1'b0);
  endtask

  task automatic test_same_cycle();
    apply(16'h0001, 16'h0002, 3'b011, 1'b0);
    chk("R9", "res first", {16'd0, res}, 32'h3);
    #1;
    opa = 16'h0010;
    #1;
    chk("R9", "res follows", {16'd0, res}, 32'h12);
  endtask

  initial begin
    void'($urandom(32'd77));
    opa = '0; opb = '0; fsel = 3'b000; cin = 1'b0;
    #2;
    chk("R3", "initial clear", {16'd0, res}, 32'h0);
    chk("R8", "initial flags", {28'd0, cout, ovf, gen_n, prop_n}, 32'h3);
    test_directed();
    test_random();
    test_nonarith();
    test_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(10 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule